// File: doc/BRIEF.md
# Field-Steered Accumulator Processor

This block is a small processor core built around one 8-bit accumulator. It fetches a 21-bit word from an internal program store every clock cycle, and its program counter simply counts up and wraps around. There is no opcode. Fixed groups of bits in the word act directly as control lines. One group picks where the operand comes from, one picks what the arithmetic unit does, and one bit decides whether the accumulator is saved to data memory. Because of this, a single word can read memory, update the accumulator and write memory all in the same cycle.

The operand can come from the external input port, from an 8-bit constant carried in the word, or from a 256-entry data memory whose address is also carried in the word. The accumulator always appears on the output port. A write port fills the program store, normally while reset is held. When reset is released, execution starts at word 0.

Top module: `accum_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and the accumulator are cleared, so `out_port` reads 0x00 after that edge.
- R2: The program counter advances by exactly one on every clock edge with `rst` low, and it wraps from 255 to 0. Word n of the program therefore executes on the (n+1)-th edge after reset is released, and again 256 edges later.
- R3: Source bits [3:2] = 00 use bits [20:13] of the word as the operand.
- R4: Source bits [3:2] = 01 use the value on `in_port` during that cycle as the operand.
- R5: Source bit [3] = 1 (bit [2] don't care) uses the data memory entry addressed by bits [12:5] as the operand.
- R6: Operation bit [1] = 1 (bit [0] don't care) loads the operand into the accumulator.
- R7: Operation bits [1:0] = 01 set the accumulator to accumulator minus operand, modulo 256.
- R8: Operation bits [1:0] = 00 set the accumulator to accumulator plus operand, modulo 256.
- R9: Bit [4] = 1 stores the accumulator value from before this cycle's update into data memory at address bits [12:5]. Bit [4] = 0 leaves data memory unchanged.
- R10: When one word both reads and writes the same data address, the read returns the contents from before the write.
- R11: `out_port` always equals the accumulator, and it changes only after the clock edge that executes a word.
- R12: A high `prog_we` at a rising edge writes `prog_data` into program word `prog_addr`. Programs loaded this way run from word 0 once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 8 | Program store write address |
| prog_data | input | 21 | Program word to write |
| in_port | input | 8 | External operand input |
| out_port | output | 8 | Accumulator contents |

## Verification
Each word takes effect at the rising edge on which the program counter points at it. The new accumulator value is visible on `out_port` right after that edge, and a memory write can first be seen by the word that executes on the next edge. The bench uses a behavioural model that steps once per clock. It drives `in_port` and compares `out_port` on the falling edge, half a cycle after each update and before the next edge. Because of this, every result is checked in the cycle in which it is due. A directed section tests same-address read/write, a store with bit [4] clear, and wrap-around arithmetic. A random section then runs the program counter through its wrap several times.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int IWORD_W  = 21;
    localparam int DATA_W   = 8;
    localparam int DADDR_W  = 8;
    localparam int PC_W     = 8;

    // Bit positions of the control fields within an instruction word
    localparam int IMM_LSB  = 13;
    localparam int ADDR_LSB = 5;
    localparam int ST_BIT   = 4;
    localparam int SRC_HI   = 3;
    localparam int SRC_LO   = 2;
    localparam int OP_HI    = 1;
    localparam int OP_LO    = 0;

    typedef enum logic [1:0] {
        SRC_IMM = 2'd0,
        SRC_INP = 2'd1,
        SRC_MEM = 2'd2
    } src_sel_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_PASS = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0]  imm;
        logic [DADDR_W-1:0] addr;
        logic               store;
        src_sel_e           src;
        alu_op_e            op;
    } ctl_t;

    // Split an instruction word into its control fields
    function automatic ctl_t split_word(input logic [IWORD_W-1:0] w);
        ctl_t c;
        c.imm   = w[IMM_LSB +: DATA_W];
        c.addr  = w[ADDR_LSB +: DADDR_W];
        c.store = w[ST_BIT];
        if (w[SRC_HI])      c.src = SRC_MEM;
        else if (w[SRC_LO]) c.src = SRC_INP;
        else                c.src = SRC_IMM;
        if (w[OP_HI])       c.op = ALU_PASS;
        else if (w[OP_LO])  c.op = ALU_SUB;
        else                c.op = ALU_ADD;
        return c;
    endfunction

    // Arithmetic: results wrap at the data width
    function automatic logic [DATA_W-1:0] alu_eval(input alu_op_e op,
                                                   input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] r;
        unique case (op)
            ALU_ADD:  r = a + b;
            ALU_SUB:  r = a - b;
            default:  r = b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/prog_store.sv
module prog_store #(
    parameter int WORD_W = acc_pkg::IWORD_W,
    parameter int ADDR_W = acc_pkg::PC_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_word;
        end
    end

    // Asynchronous fetch so a word executes in the cycle its address is held
    assign rd_word = words[rd_addr];

endmodule

// File: rtl/data_mem.sv
module data_mem #(
    parameter int DATA_W = acc_pkg::DATA_W,
    parameter int ADDR_W = acc_pkg::DADDR_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    // Read sees pre-write contents: the write lands only at the edge
    assign rdata = cells[addr];

    // R9
    mem_store_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> cells[$past(addr)] == $past(wdata));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DATA_W = acc_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] in_port,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_q
);

    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] acc_d;

    always_comb begin
        unique case (ctl.src)
            SRC_MEM: operand = mem_rdata;
            SRC_INP: operand = in_port;
            default: operand = ctl.imm;
        endcase
    end

    assign acc_d = alu_eval(ctl.op, acc_q, operand);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R6
    load_result_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == ALU_PASS) |=> acc_q == $past(operand));

    // R7
    sub_result_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == ALU_SUB) |=> acc_q == DATA_W'($past(acc_q) - $past(operand)));

    // R8
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == ALU_ADD) |=> acc_q == DATA_W'($past(acc_q) + $past(operand)));

endmodule

// File: rtl/accum_core.sv
module accum_core
    import acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [IWORD_W-1:0] prog_data,
    input  logic [DATA_W-1:0]  in_port,
    output logic [DATA_W-1:0]  out_port
);

    logic [PC_W-1:0]    pc_q;
    logic [IWORD_W-1:0] iword;
    ctl_t               ctl;
    logic [DATA_W-1:0]  mem_rdata;
    logic [DATA_W-1:0]  acc;

    // Unconditional sequencing: one word per cycle, wrapping at the end
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

    prog_store #(
        .WORD_W (IWORD_W),
        .ADDR_W (PC_W)
    ) u_prog (
        .clk     (clk),
        .wr_en   (prog_we),
        .wr_addr (prog_addr),
        .wr_word (prog_data),
        .rd_addr (pc_q),
        .rd_word (iword)
    );

    assign ctl = split_word(iword);

    data_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (DADDR_W)
    ) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.store & ~rst),
        .addr  (ctl.addr),
        .wdata (acc),
        .rdata (mem_rdata)
    );

    acc_datapath #(
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .in_port   (in_port),
        .mem_rdata (mem_rdata),
        .acc_q     (acc)
    );

    assign out_port = acc;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_q == PC_W'($past(pc_q) + 1'b1));

endmodule

// File: tb/accum_core_tb.sv
module accum_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NWORDS = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [20:0] prog_data = '0;
    logic [7:0]  in_port = '0;
    logic [7:0]  out_port;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    logic [20:0] m_prog [NWORDS];
    string       m_tag  [NWORDS];
    logic [7:0]  m_ram  [NWORDS];
    int          m_pc;
    logic [7:0]  m_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    accum_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .in_port   (in_port),
        .out_port  (out_port)
    );

    // Word encoding: imm[20:13] addr[12:5] store[4] src[3:2] op[1:0]
    function automatic logic [20:0] mk(input logic [7:0] imm, input logic [7:0] addr,
                                       input logic st, input logic [1:0] src,
                                       input logic [1:0] op);
        return {imm, addr, st, src, op};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s out_port=%02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    // One executed word: model it, let the edge pass, compare at the falling edge
    task automatic step();
        logic [20:0] w;
        logic [7:0]  opnd;
        logic [7:0]  old_acc;
        int          a;
        string       tag;
        w = m_prog[m_pc];
        tag = m_tag[m_pc];
        in_port = 8'($urandom);
        a = int'(w[12:5]);
        if (w[3])      opnd = m_ram[a];
        else if (w[2]) opnd = in_port;
        else           opnd = w[20:13];
        old_acc = m_acc;
        if (w[1])      m_acc = opnd;
        else if (w[0]) m_acc = old_acc - opnd;
        else           m_acc = old_acc + opnd;
        if (w[4]) m_ram[a] = old_acc;
        m_pc = (m_pc + 1) % NWORDS;
        @(negedge clk);
        check(tag, out_port, m_acc);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Words 0..15 store the previous accumulator to addresses 0..15
        for (int i = 0; i < 16; i++) begin
            m_prog[i] = mk(8'(i * 37 + 5), 8'(i), 1'b1, 2'b00, 2'b10);
            m_tag[i]  = (i == 0) ? "R12 R9 R3 R6" : "R9 R3 R6";
        end
        m_prog[16] = mk(8'h10, 8'd40, 1'b0, 2'b00, 2'b11); m_tag[16] = "R3 R6 load";
        m_prog[17] = mk(8'hF5, 8'd40, 1'b0, 2'b00, 2'b00); m_tag[17] = "R8 add wrap";
        m_prog[18] = mk(8'h07, 8'd40, 1'b0, 2'b00, 2'b01); m_tag[18] = "R7 sub wrap";
        m_prog[19] = mk(8'h00, 8'd5,  1'b1, 2'b01, 2'b10); m_tag[19] = "R4 R9 input";
        m_prog[20] = mk(8'h00, 8'd5,  1'b0, 2'b10, 2'b10); m_tag[20] = "R5 R9 stored";
        m_prog[21] = mk(8'h33, 8'd5,  1'b0, 2'b00, 2'b10); m_tag[21] = "R3 R6";
        m_prog[22] = mk(8'h00, 8'd5,  1'b1, 2'b11, 2'b10); m_tag[22] = "R10 old read";
        m_prog[23] = mk(8'h00, 8'd5,  1'b0, 2'b10, 2'b11); m_tag[23] = "R9 R5 new value";
        m_prog[24] = mk(8'h00, 8'd3,  1'b0, 2'b01, 2'b01); m_tag[24] = "R4 R7";
        m_prog[25] = mk(8'hAA, 8'd3,  1'b0, 2'b00, 2'b10); m_tag[25] = "R9 no store";
        m_prog[26] = mk(8'h00, 8'd3,  1'b0, 2'b10, 2'b00); m_tag[26] = "R9 R5 R8 unchanged";
        for (int i = 27; i < NWORDS; i++) begin
            logic [1:0] src;
            logic [7:0] ad;
            src = 2'($urandom);
            ad  = src[1] ? 8'($urandom_range(15)) : 8'($urandom_range(31));
            m_prog[i] = mk(8'($urandom), ad, 1'($urandom), src, 2'($urandom));
            m_tag[i]  = (i == NWORDS - 1) ? "R2 wrap" : "R11";
        end

        // R12: fill the program store through the write port while in reset
        for (int i = 0; i < NWORDS; i++) begin
            @(negedge clk);
            prog_we   = 1'b1;
            prog_addr = 8'(i);
            prog_data = m_prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
        check("R1 reset", out_port, 8'h00);

        m_pc  = 0;
        m_acc = 8'h00;
        for (int i = 0; i < NWORDS; i++) m_ram[i] = 8'h00;
        rst = 1'b0;
        // Three full passes: the counter wraps, R2
        for (int n = 0; n < 3 * NWORDS; n++) begin
            step();
        end

        // R1: reset mid-run clears the accumulator, then rerun from word 0
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", out_port, 8'h00);
        m_pc  = 0;
        m_acc = 8'h00;
        rst = 1'b0;
        for (int n = 0; n < NWORDS + 20; n++) begin
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule